// File: doc/BRIEF.md
# Pin Transition Interrupt Port

This block watches an eight-pin input port and turns chosen transitions on those pins into interrupt requests. Each pin has its own direction setting: it can react to a rising transition or to a falling one. When that transition is seen, a sticky per-pin pending bit is latched. A single request line serves the whole port. The interrupt handler reads the pending register to learn which pin fired, then clears the bits it has handled by writing that register.

Pins arrive asynchronously. Each one passes through a synchroniser before any transition is detected. Software reaches the block through a small write-strobe register bus with a combinational read path. The bus exposes four registers: the synchronised pin levels, the per-pin enable mask, the per-pin direction select, and the pending bits.

Top module: `pin_event_port`

## Requirements
- R1: After reset, the enable mask (address 1), the direction select (address 2) and the pending bits (address 3) all read as zero, and `irq_o` is low.
- R2: With a pin's direction bit at 0, a low-to-high transition on that pin sets its pending bit. The bit is set on the third rising clock edge after the pin changes.
- R3: With a pin's direction bit at 1, a high-to-low transition sets its pending bit. The opposite transition on that pin is ignored, in either setting.
- R4: A pending bit latches whether or not the pin's enable bit is set. `irq_o` stays low while no pending pin is enabled.
- R5: `irq_o` is high exactly when some pin has both its pending bit and its enable bit at 1.
- R6: A pending bit stays set until a write to address 3 loads 0 into it. The write loads every bit from the write data, so writing 1 sets a pending bit by software.
- R7: If a detected transition and a write to address 3 land in the same cycle, that pin's pending bit ends up set.
- R8: Changing a direction bit while the pin is steady sets no pending bit.
- R9: Address 0 returns the synchronised pin levels. A pin change reaches it after two rising clock edges, and not after one.
- R10: Reads of addresses 1 and 2 return the last values written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pins_i | input | 8 | Asynchronous pin levels |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 pins, 1 enable, 2 direction, 3 pending |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Shared port interrupt request |

## Verification
The bench lands a clearing write in the same cycle that a transition is detected. A design that lets the write win would silently lose that event.

It flips direction bits while the pins are steady. A detector that compares against a select-dependent value would create a pending bit from nothing.

It latches a pending bit with the enable mask clear and confirms the request stays low until the mask is set. A design that gated latching with the enable would lose the event.

It samples the pin readback one edge and two edges after a change, to pin down the synchroniser depth.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_PINS    = 2'd0,
        RA_ENABLE  = 2'd1,
        RA_DIRSEL  = 2'd2,
        RA_PENDING = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] dirsel_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // direction 0: rising, direction 1: falling
        assign hit_o[b] = dirsel_i[b] ? (prev_q[b] & ~level_i[b])
                                      : (~prev_q[b] & level_i[b]);
    end

    // R8: a hit only ever accompanies an actual level change on that pin
    p_hit_needs_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != '0) |-> ((hit_o & (level_i ^ $past(level_i))) == hit_o));
endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
    import pin_event_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]      wdata_i,
    input  logic [WIDTH-1:0]      hit_i,
    output logic [WIDTH-1:0]      enable_o,
    output logic [WIDTH-1:0]      dirsel_o,
    output logic [WIDTH-1:0]      pending_o
);
    typedef struct packed {
        logic [WIDTH-1:0] enable;
        logic [WIDTH-1:0] dirsel;
        logic [WIDTH-1:0] pending;
    } state_t;

    state_t st_d, st_q;
    logic   wr_pending;

    assign wr_pending = wr_i && (addr_i == RA_PENDING);

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == RA_ENABLE) st_d.enable = wdata_i;
        if (wr_i && addr_i == RA_DIRSEL) st_d.dirsel = wdata_i;
        if (wr_pending)                  st_d.pending = wdata_i;
        st_d.pending = st_d.pending | hit_i;  // hardware event has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o  = st_q.enable;
    assign dirsel_o  = st_q.dirsel;
    assign pending_o = st_q.pending;

    // R2: a detected transition latches its pending bit
    p_hit_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_i != '0) && !wr_pending) |=> ((pending_o & $past(hit_i)) == $past(hit_i)));

    // R7: a same-cycle clearing write does not drop a detected transition
    p_hit_beats_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_i != '0) && wr_pending) |=> ((pending_o & $past(hit_i)) == $past(hit_i)));

    // R6: without a write or a hit, pending bits hold
    p_pending_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pending && (hit_i == '0)) |=> $stable(pending_o));
endmodule

// File: rtl/pin_event_port.sv
module pin_event_port
    import pin_event_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [WIDTH-1:0]      pins_i,
    input  logic                  bus_wr_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]      bus_wdata_i,
    output logic [WIDTH-1:0]      bus_rdata_o,
    output logic                  irq_o
);
    logic [WIDTH-1:0] level_w, hit_w, enable_w, dirsel_w, pending_w;

    pin_event_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(level_w)
    );

    pin_event_detect #(.WIDTH(WIDTH)) u_detect (
        .clk(clk), .rst_n(rst_n), .level_i(level_w),
        .dirsel_i(dirsel_w), .hit_o(hit_w)
    );

    pin_event_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .hit_i(hit_w), .enable_o(enable_w),
        .dirsel_o(dirsel_w), .pending_o(pending_w)
    );

    always_comb begin
        unique case (bus_addr_i)
            RA_PINS:    bus_rdata_o = level_w;
            RA_ENABLE:  bus_rdata_o = enable_w;
            RA_DIRSEL:  bus_rdata_o = dirsel_w;
            default:    bus_rdata_o = pending_w;
        endcase
    end

    assign irq_o = |(pending_w & enable_w);

    // R4: request stays low while nothing is enabled
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w == '0) |-> !irq_o);
endmodule

// File: tb/pin_event_port_bench.sv
`timescale 1ns/1ps
module pin_event_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = '0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    pin_event_port u_pin_event_port (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(2'd1, v); check("R1 enable", v, 8'h00);
        bus_read(2'd2, v); check("R1 dirsel", v, 8'h00);
        bus_read(2'd3, v); check("R1 pending", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rise_masked;
        logic [7:0] v;
        pins[0] = 1'b1;
        idle(2);
        bus_read(2'd3, v); check("R2 not yet after two edges", v, 8'h00);
        idle(1);
        bus_read(2'd3, v); check("R2 rising latch", v, 8'h01);
        check("R4 irq masked", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_enable;
        logic [7:0] v;
        bus_write(2'd1, 8'h01);
        bus_read(2'd1, v); check("R10 enable readback", v, 8'h01);
        check("R5 irq raised", {7'd0, irq}, 8'h01);
        bus_write(2'd1, 8'h00);
        check("R4 irq after unmask off", {7'd0, irq}, 8'h00);
        bus_write(2'd1, 8'h01);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        bus_write(2'd3, 8'h00);
        bus_read(2'd3, v); check("R6 cleared", v, 8'h00);
        check("R6 irq drops", {7'd0, irq}, 8'h00);
        pins[0] = 1'b0;
        idle(4);
        bus_read(2'd3, v); check("R3 falling ignored on rise select", v, 8'h00);
    endtask

    task automatic t_fall;
        logic [7:0] v;
        bus_write(2'd2, 8'h02);
        bus_read(2'd2, v); check("R10 dirsel readback", v, 8'h02);
        pins[1] = 1'b1; idle(4);
        bus_read(2'd3, v); check("R3 rising ignored on fall select", v, 8'h00);
        pins[1] = 1'b0; idle(4);
        bus_read(2'd3, v); check("R3 falling latch", v, 8'h02);
        pins[2] = 1'b1; idle(4);
        bus_read(2'd3, v); check("R2 second pin", v, 8'h06);
        bus_write(2'd3, 8'h04);
        bus_read(2'd3, v); check("R6 per-bit clear", v, 8'h04);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_dir_change;
        logic [7:0] v;
        bus_write(2'd2, 8'hFF); idle(4);
        bus_read(2'd3, v); check("R8 select to fall", v, 8'h00);
        bus_write(2'd2, 8'h00); idle(4);
        bus_read(2'd3, v); check("R8 select to rise", v, 8'h00);
    endtask

    task automatic t_sw_set;
        logic [7:0] v;
        bus_write(2'd3, 8'h80);
        bus_read(2'd3, v); check("R6 software set", v, 8'h80);
        check("R5 irq off when bit not enabled", {7'd0, irq}, 8'h00);
        bus_write(2'd1, 8'h80);
        check("R5 irq on software bit", {7'd0, irq}, 8'h01);
        bus_write(2'd3, 8'h00);
        check("R5 irq after clear", {7'd0, irq}, 8'h00);
        bus_write(2'd1, 8'h00);
    endtask

    task automatic t_edge_wins;
        logic [7:0] v;
        pins[3] = 1'b1;
        idle(2);
        bus_write(2'd3, 8'h00);   // lands on the edge that latches the hit
        bus_read(2'd3, v); check("R7 hit beats clear", v, 8'h08);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        pins = 8'hA5;
        idle(1);
        bus_read(2'd0, v); check("R9 one edge old value", v, 8'h0C);
        idle(1);
        bus_read(2'd0, v); check("R9 two edges new value", v, 8'hA5);
        idle(2);
        bus_write(2'd3, 8'h00);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_rise_masked();
        t_enable();
        t_clear();
        t_fall();
        t_dir_change();
        t_sw_set();
        t_edge_wins();
        t_readback();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule